// File: doc/BRIEF.md
# Key-Protected Configuration Write Guard

This block sits between a simple register bus and a bank of control registers and decides, write by write, whether a store may reach its target. The registers are split into two protection domains. One covers general system settings. The other covers the clock tree, meaning PLL and clock-gate settings. Each domain has its own lock register. Writing the 32-bit key `0x51AC0FFE` to a lock register opens that domain. Writing any other value to the same lock register closes it again. Both domains come out of reset closed.

A parameter table states the address and the domain of every protected register. For each bus write, the guard raises at most one write strobe, and only when that register's domain is open or the register belongs to no domain. A write that is held back still completes on the bus without an error. The target register keeps its old value because no strobe is raised. Reads are never held back. A read of a lock register returns a one-bit open flag. A read of any other address passes the bank's read data through unchanged.

Top module: `cfg_write_guard`

## Requirements
- R1: After reset both domains are closed, the open flags `sys_unlocked` and `clk_unlocked` are 0, and no write strobe is active.
- R2: A write of `0x51AC0FFE` to the system lock address (default 0x050) sets `sys_unlocked` from the next clock edge and leaves `clk_unlocked` unchanged.
- R3: A write of `0x51AC0FFE` to the clock lock address (default 0x058) sets `clk_unlocked` from the next clock edge and leaves `sys_unlocked` unchanged.
- R4: A write of any value other than the key to a lock address clears that domain's flag, including a value that differs from the key in one bit. Writing the key to an address that is not a lock address changes neither flag.
- R5: A read of a lock address returns bit 0 equal to that domain's open flag and bits 31:1 equal to 0. The read does not change either flag.
- R6: A write to a register whose domain is closed raises no strobe. Group codes are 1 for the system domain and 2 for the clock domain.
- R7: A write to a register whose domain is open raises `wr_strobe[i]` for exactly one cycle after the clock edge that takes the write. In that cycle `wr_data` holds the written data.
- R8: A register with group code 0 receives its strobe on every write, whatever the state of the locks.
- R9: A read of a non-lock address returns `bank_rdata` unchanged and raises no strobe.
- R10: An open domain stays open across any number of writes to its registers, until a non-key write to its lock address or a reset.
- R11: At most one bit of `wr_strobe` is set in any cycle, and a strobe appears only in the cycle after a bus write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Bus access in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data: lock status or bank data |
| bank_rdata | input | DATA_W | Read data from the protected register bank |
| wr_strobe | output | NREG | Gated write enables, one per table slot |
| wr_data | output | DATA_W | Data that goes with `wr_strobe` |
| sys_unlocked | output | 1 | System domain open |
| clk_unlocked | output | 1 | Clock domain open |

## Verification
The hardest case to reach from the ports is an open domain that must survive a long run of protected writes and reads, followed by a single write whose value misses the key by one bit. The bench opens the system domain and writes twenty times to one of its registers, checking the strobe after each write. It then writes the key with its lowest bit flipped and confirms that the system domain closes while the clock domain stays open. It also writes the exact key to an ordinary register address to show that the key value alone opens nothing.

// File: rtl/wg_pkg.sv
package wg_pkg;

  typedef enum logic [1:0] {
    GRP_FREE = 2'd0,
    GRP_SYS  = 2'd1,
    GRP_CLK  = 2'd2,
    GRP_RSVD = 2'd3
  } grp_e;

  // Write permission for one table slot, given the two domain states.
  function automatic logic slot_writable(input logic [1:0] code,
                                         input logic sys_open,
                                         input logic clk_open);
    case (grp_e'(code))
      GRP_FREE: slot_writable = 1'b1;
      GRP_SYS:  slot_writable = sys_open;
      GRP_CLK:  slot_writable = clk_open;
      default:  slot_writable = 1'b0;
    endcase
  endfunction

  // Status word returned when a lock register is read.
  function automatic logic [31:0] lock_status_word(input logic open);
    lock_status_word = {31'd0, open};
  endfunction

endpackage

// File: rtl/wg_key_lock.sv
module wg_key_lock #(
  parameter int                DATA_W = 32,
  parameter logic [DATA_W-1:0] KEY    = 32'h51AC0FFE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              open_q,
  output logic              unlock_evt,
  output logic              relock_evt
);

  logic key_ok;

  assign key_ok     = (wdata == KEY);
  assign unlock_evt = lock_wr &&  key_ok;
  assign relock_evt = lock_wr && !key_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          open_q <= 1'b0;
    else if (unlock_evt) open_q <= 1'b1;
    else if (relock_evt) open_q <= 1'b0;
  end

endmodule

// File: rtl/wg_decode.sv
module wg_decode #(
  parameter int                   NREG          = 6,
  parameter int                   ADDR_W        = 12,
  parameter logic [NREG*ADDR_W-1:0] REG_ADDRS   = '0,
  parameter logic [ADDR_W-1:0]    SYS_LOCK_ADDR = 12'h050,
  parameter logic [ADDR_W-1:0]    CLK_LOCK_ADDR = 12'h058
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              sys_lock_sel,
  output logic              clk_lock_sel,
  output logic [NREG-1:0]   slot_hit
);

  logic lock_sel;

  assign sys_lock_sel = (addr == SYS_LOCK_ADDR);
  assign clk_lock_sel = (addr == CLK_LOCK_ADDR);
  assign lock_sel     = sys_lock_sel | clk_lock_sel;

  for (genvar i = 0; i < NREG; i++) begin : g_slot
    // A lock address always wins over a table entry.
    assign slot_hit[i] = !lock_sel && (addr == REG_ADDRS[i*ADDR_W +: ADDR_W]);
  end

endmodule

// File: rtl/wg_strobe_gate.sv
module wg_strobe_gate
  import wg_pkg::*;
#(
  parameter int                NREG       = 6,
  parameter int                DATA_W     = 32,
  parameter logic [2*NREG-1:0] REG_GROUPS = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_cmd,
  input  logic [NREG-1:0]   slot_hit,
  input  logic              sys_open,
  input  logic              clk_open,
  input  logic [DATA_W-1:0] wdata,
  output logic [NREG-1:0]   slot_pass,
  output logic [NREG-1:0]   strobe_q,
  output logic [DATA_W-1:0] data_q
);

  for (genvar i = 0; i < NREG; i++) begin : g_gate
    assign slot_pass[i] = wr_cmd && slot_hit[i] &&
                          slot_writable(REG_GROUPS[2*i +: 2], sys_open, clk_open);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= '0;
      data_q   <= '0;
    end else begin
      strobe_q <= slot_pass;
      if (wr_cmd) data_q <= wdata;
    end
  end

endmodule

// File: rtl/cfg_write_guard.sv
module cfg_write_guard
  import wg_pkg::*;
#(
  parameter int                     NREG          = 6,
  parameter int                     ADDR_W        = 12,
  parameter int                     DATA_W        = 32,
  parameter logic [DATA_W-1:0]      KEY           = 32'h51AC0FFE,
  parameter logic [ADDR_W-1:0]      SYS_LOCK_ADDR = 12'h050,
  parameter logic [ADDR_W-1:0]      CLK_LOCK_ADDR = 12'h058,
  parameter logic [NREG*ADDR_W-1:0] REG_ADDRS     =
    {12'h1DC, 12'h124, 12'h11C, 12'h080, 12'h00C, 12'h000},
  parameter logic [2*NREG-1:0]      REG_GROUPS    = 12'b00_10_10_10_01_01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] bank_rdata,
  output logic [NREG-1:0]   wr_strobe,
  output logic [DATA_W-1:0] wr_data,
  output logic              sys_unlocked,
  output logic              clk_unlocked
);

  // Named internal events, exposed for the checker.
  logic            wr_cmd;
  logic            sys_lock_sel;
  logic            clk_lock_sel;
  logic [NREG-1:0] slot_hit;
  logic [NREG-1:0] slot_pass;
  logic            sys_unlock_evt;
  logic            sys_relock_evt;
  logic            clk_unlock_evt;
  logic            clk_relock_evt;

  assign wr_cmd = bus_valid && bus_write;

  wg_decode #(
    .NREG(NREG), .ADDR_W(ADDR_W), .REG_ADDRS(REG_ADDRS),
    .SYS_LOCK_ADDR(SYS_LOCK_ADDR), .CLK_LOCK_ADDR(CLK_LOCK_ADDR)
  ) u_decode (
    .addr(bus_addr),
    .sys_lock_sel(sys_lock_sel),
    .clk_lock_sel(clk_lock_sel),
    .slot_hit(slot_hit)
  );

  wg_key_lock #(.DATA_W(DATA_W), .KEY(KEY)) u_sys_lock (
    .clk(clk), .rst_n(rst_n),
    .lock_wr(wr_cmd && sys_lock_sel),
    .wdata(bus_wdata),
    .open_q(sys_unlocked),
    .unlock_evt(sys_unlock_evt),
    .relock_evt(sys_relock_evt)
  );

  wg_key_lock #(.DATA_W(DATA_W), .KEY(KEY)) u_clk_lock (
    .clk(clk), .rst_n(rst_n),
    .lock_wr(wr_cmd && clk_lock_sel),
    .wdata(bus_wdata),
    .open_q(clk_unlocked),
    .unlock_evt(clk_unlock_evt),
    .relock_evt(clk_relock_evt)
  );

  wg_strobe_gate #(.NREG(NREG), .DATA_W(DATA_W), .REG_GROUPS(REG_GROUPS)) u_gate (
    .clk(clk), .rst_n(rst_n),
    .wr_cmd(wr_cmd),
    .slot_hit(slot_hit),
    .sys_open(sys_unlocked),
    .clk_open(clk_unlocked),
    .wdata(bus_wdata),
    .slot_pass(slot_pass),
    .strobe_q(wr_strobe),
    .data_q(wr_data)
  );

  // Read path: lock status for lock addresses, bank data otherwise.
  always_comb begin
    if (sys_lock_sel)      bus_rdata = DATA_W'(lock_status_word(sys_unlocked));
    else if (clk_lock_sel) bus_rdata = DATA_W'(lock_status_word(clk_unlocked));
    else                   bus_rdata = bank_rdata;
  end

endmodule

// File: rtl/wg_checker.sv
module wg_checker #(
  parameter int                NREG          = 6,
  parameter int                ADDR_W        = 12,
  parameter int                DATA_W        = 32,
  parameter logic [DATA_W-1:0] KEY           = 32'h51AC0FFE,
  parameter logic [ADDR_W-1:0] SYS_LOCK_ADDR = 12'h050,
  parameter logic [ADDR_W-1:0] CLK_LOCK_ADDR = 12'h058,
  parameter logic [2*NREG-1:0] REG_GROUPS    = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [NREG-1:0]   wr_strobe,
  input logic              sys_unlocked,
  input logic              clk_unlocked
);

  assert_strobe_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_strobe));

  assert_strobe_after_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_strobe) |-> $past(bus_valid && bus_write));

  assert_sys_open_by_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_unlocked) |->
      $past(bus_valid && bus_write && bus_addr == SYS_LOCK_ADDR && bus_wdata == KEY));

  assert_clk_open_by_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_unlocked) |->
      $past(bus_valid && bus_write && bus_addr == CLK_LOCK_ADDR && bus_wdata == KEY));

  assert_sys_close_by_other_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_unlocked) |->
      $past(bus_valid && bus_write && bus_addr == SYS_LOCK_ADDR && bus_wdata != KEY));

  assert_clk_close_by_other_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_unlocked) |->
      $past(bus_valid && bus_write && bus_addr == CLK_LOCK_ADDR && bus_wdata != KEY));

  assert_lock_read_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && (bus_addr == SYS_LOCK_ADDR || bus_addr == CLK_LOCK_ADDR))
      |-> (bus_rdata[DATA_W-1:1] == '0));

  assert_read_no_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> (wr_strobe == '0));

  assert_sys_persist_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_unlocked && !(bus_valid && bus_write && bus_addr == SYS_LOCK_ADDR))
      |=> sys_unlocked);

  assert_clk_persist_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_unlocked && !(bus_valid && bus_write && bus_addr == CLK_LOCK_ADDR))
      |=> clk_unlocked);

  for (genvar i = 0; i < NREG; i++) begin : g_slot_chk
    if (REG_GROUPS[2*i +: 2] == 2'd1) begin : g_sys
      assert_sys_locked_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe[i] |-> $past(sys_unlocked));
    end else if (REG_GROUPS[2*i +: 2] == 2'd2) begin : g_clk
      assert_clk_locked_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe[i] |-> $past(clk_unlocked));
    end
  end

endmodule

bind cfg_write_guard wg_checker #(
  .NREG(NREG), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY(KEY),
  .SYS_LOCK_ADDR(SYS_LOCK_ADDR), .CLK_LOCK_ADDR(CLK_LOCK_ADDR),
  .REG_GROUPS(REG_GROUPS)
) u_wg_checker (
  .clk(clk), .rst_n(rst_n),
  .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .wr_strobe(wr_strobe),
  .sys_unlocked(sys_unlocked), .clk_unlocked(clk_unlocked)
);

// File: tb/test_cfg_write_guard.sv
`timescale 1ns/1ps
module test_cfg_write_guard;

  localparam logic [11:0] SYS_LK = 12'h050;
  localparam logic [11:0] CLK_LK = 12'h058;
  localparam logic [31:0] KEYV   = 32'h51AC0FFE;
  // Bench view of the default table: slot -> address.
  localparam logic [11:0] A_S0 = 12'h000;  // slot 0, system
  localparam logic [11:0] A_S1 = 12'h00C;  // slot 1, system
  localparam logic [11:0] A_C2 = 12'h080;  // slot 2, clock
  localparam logic [11:0] A_C3 = 12'h11C;  // slot 3, clock
  localparam logic [11:0] A_C4 = 12'h124;  // slot 4, clock
  localparam logic [11:0] A_F5 = 12'h1DC;  // slot 5, free

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] bank_rdata = 32'h0;
  logic [5:0]  wr_strobe;
  logic [31:0] wr_data;
  logic        sys_unlocked;
  logic        clk_unlocked;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  cfg_write_guard i_cfg_write_guard (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bank_rdata(bank_rdata),
    .wr_strobe(wr_strobe), .wr_data(wr_data),
    .sys_unlocked(sys_unlocked), .clk_unlocked(clk_unlocked)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // Drive one write; returns after the edge that takes it, at a falling edge.
  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic expect_strobe(input logic [5:0] exp, input logic [31:0] d, input string req);
    chk(wr_strobe == exp, req, 32'(wr_strobe), 32'(exp));
    if (exp != 0) chk(wr_data == d, req, wr_data, d);
  endtask

  task automatic t_reset;
    logic [31:0] r;
    chk(sys_unlocked == 1'b0, "R1 sys flag", 32'(sys_unlocked), 0);
    chk(clk_unlocked == 1'b0, "R1 clk flag", 32'(clk_unlocked), 0);
    chk(wr_strobe == '0, "R1 strobe", 32'(wr_strobe), 0);
    bus_rd(SYS_LK, r); chk(r == 32'd0, "R5 sys lock read", r, 0);
    bus_rd(CLK_LK, r); chk(r == 32'd0, "R5 clk lock read", r, 0);
  endtask

  task automatic t_locked_writes;
    bus_wr(A_S0, 32'h1111_0000); expect_strobe(6'b000000, 0, "R6 sys locked");
    bus_wr(A_C2, 32'h2222_0000); expect_strobe(6'b000000, 0, "R6 clk locked");
  endtask

  task automatic t_free_slot;
    bus_wr(A_F5, 32'hA5A5_0005); expect_strobe(6'b100000, 32'hA5A5_0005, "R8 free slot locked");
    @(negedge clk);
    chk(wr_strobe == '0, "R7 strobe one cycle", 32'(wr_strobe), 0);
    bus_wr(A_F5, KEYV); expect_strobe(6'b100000, KEYV, "R8 free slot gets key data");
    chk(sys_unlocked == 1'b0 && clk_unlocked == 1'b0, "R4 key to data addr",
        {30'd0, sys_unlocked, clk_unlocked}, 0);
  endtask

  task automatic t_sys_open;
    logic [31:0] r;
    bus_wr(SYS_LK, KEYV);
    chk(wr_strobe == '0, "R2 lock write no strobe", 32'(wr_strobe), 0);
    bus_rd(SYS_LK, r); chk(r == 32'd1, "R2 sys open", r, 1);
    bus_rd(CLK_LK, r); chk(r == 32'd0, "R2 clk untouched", r, 0);
    bus_wr(A_S1, 32'h0000_0401); expect_strobe(6'b000010, 32'h0000_0401, "R7 sys write");
    bus_wr(A_C3, 32'h0000_0FFC); expect_strobe(6'b000000, 0, "R6 clk still locked");
  endtask

  task automatic t_clk_open;
    logic [31:0] r;
    bus_wr(CLK_LK, KEYV);
    bus_rd(CLK_LK, r); chk(r == 32'd1, "R3 clk open", r, 1);
    chk(sys_unlocked == 1'b1, "R3 sys unchanged", 32'(sys_unlocked), 1);
    bus_wr(A_C2, 32'h1001_808C); expect_strobe(6'b000100, 32'h1001_808C, "R7 clk slot2");
    bus_wr(A_C3, 32'h0000_0FFC); expect_strobe(6'b001000, 32'h0000_0FFC, "R7 clk slot3");
    bus_wr(A_C4, 32'h0000_007F); expect_strobe(6'b010000, 32'h0000_007F, "R7 clk slot4");
  endtask

  task automatic t_persist;
    for (int k = 0; k < 20; k++) begin
      bus_wr(A_S0, 32'h100 + 32'(k));
      expect_strobe(6'b000001, 32'h100 + 32'(k), "R10 repeated sys write");
    end
    bus_wr(CLK_LK, KEYV);
    chk(clk_unlocked == 1'b1, "R10 key again keeps open", 32'(clk_unlocked), 1);
    chk(sys_unlocked == 1'b1, "R10 sys still open", 32'(sys_unlocked), 1);
  endtask

  task automatic t_reads;
    logic [31:0] r;
    bank_rdata = 32'hDEAD_BEEF;
    bus_rd(A_C2, r);
    chk(r == 32'hDEAD_BEEF, "R9 read pass-through", r, 32'hDEAD_BEEF);
    chk(wr_strobe == '0, "R9 read no strobe", 32'(wr_strobe), 0);
    bus_rd(SYS_LK, r);
    chk(r == 32'd1, "R5 lock read ignores bank", r, 1);
    chk(sys_unlocked == 1'b1, "R5 read keeps flag", 32'(sys_unlocked), 1);
  endtask

  task automatic t_relock;
    logic [31:0] r;
    bus_wr(SYS_LK, KEYV ^ 32'h1);
    bus_rd(SYS_LK, r); chk(r == 32'd0, "R4 near-key relocks sys", r, 0);
    chk(clk_unlocked == 1'b1, "R4 clk unaffected", 32'(clk_unlocked), 1);
    bus_wr(A_S0, 32'h5555_5555); expect_strobe(6'b000000, 0, "R6 sys relocked");
    bus_wr(A_C4, 32'h0000_0033); expect_strobe(6'b010000, 32'h33, "R7 clk still open");
    bus_wr(CLK_LK, 32'h0);
    bus_rd(CLK_LK, r); chk(r == 32'd0, "R4 zero relocks clk", r, 0);
    bus_wr(A_C4, 32'h0000_0044); expect_strobe(6'b000000, 0, "R6 clk relocked");
    bus_wr(A_F5, 32'h0000_0066); expect_strobe(6'b100000, 32'h66, "R8 free after relock");
  endtask

  initial begin
    fork
      begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_locked_writes();
        t_free_slot();
        t_sys_open();
        t_clk_open();
        t_persist();
        t_reads();
        t_relock();
      end
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule